// File: doc/BRIEF.md
# RGB Brightness and Contrast Adjuster

This block adjusts the contrast and brightness of a stream of packed 24-bit RGB pixels. Each colour channel has its own settings. The 8-bit sample is first scaled by an unsigned 8-bit gain, in which 128 stands for unity, so the usable range runs from zero to just under twice the input. The scaled value is rounded to the nearest integer. A signed 8-bit offset is then added to it. The sum is clamped into the range 0 to 255.

The block sits inline in a display pipeline between colour conversion and gamma. Upstream logic presents a pixel with a valid flag together with the six current setting values. The adjusted pixel comes out one clock later, with its own valid flag. The settings are captured on the same edge as the pixel they apply to, so a write that lands partway through a frame cannot give one pixel mixed settings across its channels.

Top module: `rgb_bc_adjust`

## Requirements
- R1: The pixel word carries green in bits [23:16], blue in bits [15:8] and red in bits [7:0]. Each channel uses the gain and offset port named for its colour.
- R2: A channel's scaled value is floor((sample × gain + 64) / 128), which is round-to-nearest division of the 16-bit product by 128.
- R3: A gain of 128 with an offset of 0 returns the input sample unchanged.
- R4: The offset is a two's-complement value from -128 to +127 and is added after scaling. For example, sample 170 with gain 160 and offset 30 gives 243.
- R5: When scaled value plus offset exceeds 255, the channel outputs 255.
- R6: When scaled value plus offset is below 0, the channel outputs 0.
- R7: `out_valid` equals `in_valid` delayed by one clock. The result for a pixel accepted at an edge appears on `out_pix` after that same edge.
- R8: While `in_valid` is low, `out_pix` holds its last value, and changes on the setting ports have no effect on it. Settings are taken only on the edge that accepts a pixel.
- R9: While `rst_n` is low, `out_valid` and `out_pix` are 0.
- R10: The three channels are computed independently. A setting of one channel never alters another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel, G/B/R from high byte to low byte |
| gain_g | input | 8 | Green contrast gain, 128 = unity |
| gain_b | input | 8 | Blue contrast gain, 128 = unity |
| gain_r | input | 8 | Red contrast gain, 128 = unity |
| ofs_g | input | 8 | Green brightness offset, signed |
| ofs_b | input | 8 | Blue brightness offset, signed |
| ofs_r | input | 8 | Red brightness offset, signed |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Adjusted pixel, same packing as input |

## Verification
Unity settings show whether the data path passes samples through without distortion. The worked point 170/160/30 and the products that land exactly on, just under and just over a half step tell truncation apart from correct rounding. Extreme samples with maximum gain and extreme offsets of both signs tell the upper clamp from the lower one; they also show whether a wrapped sum near 511 is wrongly read as negative. Different settings on each channel show whether the byte lanes are packed in the right order. A stretch of random pixels with gaps, while settings move during the gaps, separates correct holding and per-pixel capture from leakage of settings between pixels.

// File: rtl/rgb_bc_adjust.sv
module rgb_bc_adjust #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3*CW-1:0] in_pix,
  input  logic [CW-1:0] gain_g,
  input  logic [CW-1:0] gain_b,
  input  logic [CW-1:0] gain_r,
  input  logic [CW-1:0] ofs_g,
  input  logic [CW-1:0] ofs_b,
  input  logic [CW-1:0] ofs_r,
  output logic          out_valid,
  output logic [3*CW-1:0] out_pix
);
  localparam int PW = 2*CW;
  localparam int SW = CW+1;
  localparam int TW = CW+2;

  logic [3*CW-1:0] gain_v, ofs_v, adj;
  assign gain_v = {gain_g, gain_b, gain_r};
  assign ofs_v  = {ofs_g, ofs_b, ofs_r};

  for (genvar k = 0; k < 3; k++) begin : g_ch
    logic [PW-1:0] prod;
    logic [SW-1:0] scaled;
    logic [TW-1:0] total;
    logic [CW-1:0] bofs;
    assign bofs   = ofs_v[k*CW +: CW];
    assign prod   = in_pix[k*CW +: CW] * gain_v[k*CW +: CW];
    assign scaled = prod[PW-1:CW-1] + {{(SW-1){1'b0}}, prod[CW-2]};
    assign total  = {1'b0, scaled} + {bofs[CW-1], bofs[CW-1], bofs};
    assign adj[k*CW +: CW] = (total[TW-1:TW-2] == 2'b11) ? '0 :
                             (total[TW-1:TW-2] == 2'b00) ? total[CW-1:0] : '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= adj;
    end
  end
endmodule

// File: rtl/rgb_bc_adjust_chk.sv
module rgb_bc_adjust_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3*CW-1:0] in_pix,
  input logic [CW-1:0] gain_g,
  input logic [CW-1:0] gain_b,
  input logic [CW-1:0] gain_r,
  input logic [CW-1:0] ofs_g,
  input logic [CW-1:0] ofs_b,
  input logic [CW-1:0] ofs_r,
  input logic          out_valid,
  input logic [3*CW-1:0] out_pix
);
  localparam logic [CW-1:0] UNITY = CW'(1 << (CW-1));
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (out_valid == 1'b0 && out_pix == '0));

  a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid == $past(in_valid));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(in_valid) |-> $stable(out_pix));

  a_r3_unity_pass: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(in_valid && gain_g == UNITY && gain_b == UNITY && gain_r == UNITY &&
          ofs_g == '0 && ofs_b == '0 && ofs_r == '0) |-> out_pix == $past(in_pix));

  a_r5_clamp_high: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(in_valid && in_pix == '1 && gain_g == '1 && gain_b == '1 && gain_r == '1 &&
          !ofs_g[CW-1] && !ofs_b[CW-1] && !ofs_r[CW-1]) |-> out_pix == '1);

  a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(in_valid && in_pix == '0 && ofs_g[CW-1] && ofs_b[CW-1] && ofs_r[CW-1])
      |-> out_pix == '0);
endmodule

bind rgb_bc_adjust rgb_bc_adjust_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .gain_g(gain_g), .gain_b(gain_b), .gain_r(gain_r),
  .ofs_g(ofs_g), .ofs_b(ofs_b), .ofs_r(ofs_r),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/test_rgb_bc_adjust.sv
`timescale 1ns/1ps
module test_rgb_bc_adjust;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_pix = '0;
  logic [7:0] gain_g = 8'd128, gain_b = 8'd128, gain_r = 8'd128;
  logic [7:0] ofs_g = '0, ofs_b = '0, ofs_r = '0;
  logic out_valid;
  logic [23:0] out_pix;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  rgb_bc_adjust i_rgb_bc_adjust (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .gain_g(gain_g), .gain_b(gain_b), .gain_r(gain_r),
    .ofs_g(ofs_g), .ofs_b(ofs_b), .ofs_r(ofs_r),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int chan(int x, int c, int b);
    int v;
    v = (x * c + 64) / 128 + b;
    if (v > 255) v = 255;
    if (v < 0) v = 0;
    return v;
  endfunction

  function automatic logic [23:0] model(logic [23:0] p);
    logic [23:0] r;
    r[23:16] = 8'(chan(int'(p[23:16]), int'(gain_g), int'($signed(ofs_g))));
    r[15:8]  = 8'(chan(int'(p[15:8]),  int'(gain_b), int'($signed(ofs_b))));
    r[7:0]   = 8'(chan(int'(p[7:0]),   int'(gain_r), int'($signed(ofs_r))));
    return r;
  endfunction

  logic m_valid = 1'b0;
  logic [23:0] m_pix = '0;
  string m_tag = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_pix   <= '0;
      m_tag   <= "R9";
    end else begin
      m_valid <= in_valid;
      if (in_valid) m_pix <= model(in_pix);
      m_tag <= tag;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== m_valid || out_pix !== m_pix) begin
        fails++;
        $display("FAIL %s: out_valid=%0b out_pix=%06h expected valid=%0b pix=%06h",
                 m_tag, out_valid, out_pix, m_valid, m_pix);
      end
    end
  end

  task automatic set(input logic [7:0] gg, gb, gr, og, ob, orr);
    gain_g = gg; gain_b = gb; gain_r = gr;
    ofs_g = og; ofs_b = ob; ofs_r = orr;
  endtask

  task automatic push(input logic [23:0] p, input string t);
    @(negedge clk);
    tag = t;
    in_pix = p;
    in_valid = 1'b1;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tag = t;
      in_valid = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    set(8'd128, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0);
    push(24'h12AB7F, "R3 unity");
    push(24'hFF0001, "R3 unity");
    idle(1, "R7");

    set(8'd160, 8'd160, 8'd160, 8'd30, 8'd30, 8'd30);
    push(24'hAAAAAA, "R4 worked point 243");
    set(8'd64, 8'd63, 8'd65, 8'd0, 8'd0, 8'd0);
    push(24'h010101, "R2 half-step rounding");
    set(8'd3, 8'd1, 8'd129, 8'd0, 8'd0, 8'd0);
    push(24'h15403F, "R2 rounding");

    set(8'd255, 8'd255, 8'd255, 8'd127, 8'd127, 8'd127);
    push(24'hFFFFFF, "R5 clamp high");
    set(8'd255, 8'd255, 8'd255, 8'h80, 8'h80, 8'h80);
    push(24'hFFFFFF, "R5 wrap near 511 stays high");
    set(8'd128, 8'd128, 8'd128, 8'h80, 8'hF6, 8'hFF);
    push(24'h0A0A00, "R6 clamp low");
    set(8'd0, 8'd0, 8'd0, 8'hC8, 8'h01, 8'h80);
    push(24'h808080, "R6 zero gain");

    set(8'd255, 8'd128, 8'd0, 8'h05, 8'hF0, 8'h10);
    push(24'h405060, "R1 lane packing");
    set(8'd128, 8'd200, 8'd128, 8'd0, 8'd0, 8'd0);
    push(24'h404040, "R10 channel independence");

    @(negedge clk);
    tag = "R8 hold";
    in_valid = 1'b0;
    set(8'd7, 8'd9, 8'd11, 8'h40, 8'hC0, 8'h22);
    in_pix = 24'h000000;
    idle(3, "R8 hold");

    lf = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      tag = "R7 stream";
      in_valid = lf[3] | lf[9];
      in_pix = lf[27:4];
      if (lf[12]) set(lf[7:0], lf[15:8], lf[23:16], lf[31:24], lf[11:4], lf[19:12]);
    end

    @(negedge clk);
    tag = "R9";
    in_valid = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule